// File: doc/BRIEF.md
# Single-Bit Toggle Detector

This block watches one serial data bit that is sampled on every rising clock edge. It raises a flag whenever the current sample differs from the sample taken on the clock before, whether the bit rose from 0 to 1 or fell from 1 to 0. The block is meant for places where a slow control or status line must be turned into a one-cycle event pulse, for example to wake a handler when a line toggles.

Two independent state machines produce the flag side by side. The first is a five-state machine whose flag is decoded purely from its state. The second is a three-state machine that forms the flag from its state and the input, then holds that value in an output register. Both outputs therefore change only at the clock edge and report the same event one clock after the second of the two differing samples. After any reset the first sample only establishes history, so it can never produce a flag.

Top module: `toggle_detect`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, both machines return to their idle state, and after that edge `flag_moore` and `flag_mealy` are 0.
- R2: The first sample taken with `rst_n` high after a reset never raises either flag, whatever its value.
- R3: When a sample differs from the previous sample and both were taken since the last reset, `flag_moore` is 1 for the cycle that follows that sampling edge.
- R4: When a sample equals the previous sample, `flag_moore` is 0 for the cycle that follows that sampling edge.
- R5: `flag_mealy` is a registered output that is 1 after a sampling edge exactly when the sample at that edge differs from the previous sample, and 0 otherwise.
- R6: Out of reset, `flag_moore` and `flag_mealy` hold the same value in every cycle for any input sequence.
- R7: A reset asserted in the middle of a stream discards the history: the first sample after it gives no flag even when it differs from the last sample before the reset, and the second sample is again compared normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the input is sampled on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| din | input | 1 | Serial data bit being watched |
| flag_moore | output | 1 | Toggle flag decoded from the five-state machine |
| flag_mealy | output | 1 | Toggle flag from the registered three-state machine |

## Verification
A wrong internal state shows at the ports within one clock: a machine that forgets or misremembers the last sample asserts or misses a flag on the very next sampling edge, and the two outputs then disagree in that same cycle. A machine that fails to leave idle, or leaves it with the wrong history, shows up on the second sample after reset. Every input sequence of eight samples after reset is swept, and a long random stream with occasional resets mid-stream covers the recovery from reset with stale history.

// File: rtl/toggle_pkg.sv
// Shared state types for the toggle detector.
// Assumes: both machines use a binary encoding with idle as the all-zero code.
package toggle_pkg;

    // States of the five-state machine; flag is decoded from ROSE and FELL.
    typedef enum logic [2:0] {
        MO_IDLE = 3'd0,  // no sample seen since reset
        MO_LOW  = 3'd1,  // last sample 0, no toggle
        MO_HIGH = 3'd2,  // last sample 1, no toggle
        MO_ROSE = 3'd3,  // last sample 1 after a 0
        MO_FELL = 3'd4   // last sample 0 after a 1
    } moore_st_t;

    // States of the three-state machine; only the last sample is stored.
    typedef enum logic [1:0] {
        ME_IDLE = 2'd0,  // no sample seen since reset
        ME_ZERO = 2'd1,  // last sample 0
        ME_ONE  = 2'd2   // last sample 1
    } mealy_st_t;

endpackage

// File: rtl/toggle_moore.sv
// Five-state detector whose flag depends on the state alone.
// Does: records the last sample and whether it was a toggle.
// Assumes: din is synchronous to clk; rst_n is synchronous, active low.
module toggle_moore
    import toggle_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic flag
);

    moore_st_t state_q;
    moore_st_t state_d;

    // Next-state selection from the current state and the new sample.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MO_IDLE: state_d = din ? MO_HIGH : MO_LOW;
            MO_LOW:  state_d = din ? MO_ROSE : MO_LOW;
            MO_HIGH: state_d = din ? MO_HIGH : MO_FELL;
            MO_ROSE: state_d = din ? MO_HIGH : MO_FELL;
            MO_FELL: state_d = din ? MO_ROSE : MO_LOW;
            default: state_d = MO_IDLE;
        endcase
    end

    // State register with synchronous reset to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MO_IDLE;
        else        state_q <= state_d;
    end

    // Flag decode: high only in the two toggle states.
    always_comb begin
        flag = (state_q == MO_ROSE) || (state_q == MO_FELL);
    end

    // R1: reset leaves the machine idle with the flag low.
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (state_q == MO_IDLE) && !flag);

    // R2: the sample taken from idle never flags.
    a_r2_first_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MO_IDLE) |=> !flag);

    // R3: a 1 after a stored 0 flags on the next cycle.
    a_r3_rise_flags: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == MO_LOW || state_q == MO_FELL) && din) |=> flag);

    // R3: a 0 after a stored 1 flags on the next cycle.
    a_r3_fall_flags: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == MO_HIGH || state_q == MO_ROSE) && !din) |=> flag);

    // R4: a repeated sample leaves the flag low.
    a_r4_steady_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == MO_LOW || state_q == MO_FELL) && !din) |=> !flag);

endmodule

// File: rtl/toggle_mealy_reg.sv
// Three-state detector with its flag held in an output register.
// Does: forms the flag from state and input, then registers it.
// Assumes: din is synchronous to clk; rst_n is synchronous, active low.
module toggle_mealy_reg
    import toggle_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic flag
);

    mealy_st_t state_q;
    mealy_st_t state_d;
    logic      flag_d;
    logic      flag_q;

    // Next state and unregistered flag from the state and the new sample.
    always_comb begin
        state_d = din ? ME_ONE : ME_ZERO;
        unique case (state_q)
            ME_IDLE: flag_d = 1'b0;
            ME_ZERO: flag_d = din;
            ME_ONE:  flag_d = !din;
            default: flag_d = 1'b0;
        endcase
    end

    // State and output registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ME_IDLE;
            flag_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            flag_q  <= flag_d;
        end
    end

    assign flag = flag_q;

    // R1: reset leaves the machine idle with the flag low.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (state_q == ME_IDLE) && !flag);

    // R5: a 1 after a stored 0 sets the registered flag.
    a_r5_rise_reg: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ME_ZERO && din) |=> flag);

    // R5: a repeated 1 leaves the registered flag low.
    a_r5_hold_reg: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ME_ONE && din) |=> !flag);

endmodule

// File: rtl/toggle_detect.sv
// Top of the toggle detector: runs both machine styles on the same input.
// Does: exposes the state-decoded flag and the registered flag.
// Assumes: rst_n is synchronous, active low, and held for at least one edge.
module toggle_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic flag_moore,
    output logic flag_mealy
);

    // State-decoded detector.
    toggle_moore u_moore (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (din),
        .flag  (flag_moore)
    );

    // Registered-output detector.
    toggle_mealy_reg u_mealy (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (din),
        .flag  (flag_mealy)
    );

    // R6: the two machines agree in every cycle out of reset.
    a_r6_flags_agree: assert property (@(posedge clk) disable iff (!rst_n)
        flag_moore == flag_mealy);

endmodule

// File: tb/toggle_detect_tb.sv
module toggle_detect_tb;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic din = 1'b0;
    logic flag_moore;
    logic flag_mealy;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Reference model state.
    bit prev = 1'b0;
    bit valid = 1'b0;
    bit after_mid = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    toggle_detect u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .din        (din),
        .flag_moore (flag_moore),
        .flag_mealy (flag_mealy)
    );

    task automatic check(input string tag, input string what, input logic got, input logic exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %b expected %b at %0t", tag, what, got, exp, $time);
        end
    endtask

    // One clock: drive at the falling edge, update model at the rising edge, check after.
    task automatic cycle(input bit r, input bit d);
        bit exp;
        bit first;
        @(negedge clk);
        rst_n = r;
        din = d;
        @(posedge clk);
        first = 1'b0;
        if (!r) begin
            valid = 1'b0;
            exp = 1'b0;
        end else begin
            first = !valid;
            exp = valid && (d != prev);
            prev = d;
            valid = 1'b1;
        end
        #(CLK_PERIOD/4);
        if (!r) begin
            check("R1", "moore in reset", flag_moore, 1'b0);
            check("R1", "mealy in reset", flag_mealy, 1'b0);
        end else if (first) begin
            if (after_mid) begin
                check("R7", "moore first after mid reset", flag_moore, 1'b0);
                check("R7", "mealy first after mid reset", flag_mealy, 1'b0);
            end else begin
                check("R2", "moore first sample", flag_moore, 1'b0);
                check("R2", "mealy first sample", flag_mealy, 1'b0);
            end
        end else begin
            if (exp) check("R3", "moore toggle", flag_moore, 1'b1);
            else     check("R4", "moore steady", flag_moore, 1'b0);
            check("R5", "mealy registered", flag_mealy, exp);
            check("R6", "flags agree", flag_mealy, flag_moore);
        end
    endtask

    initial begin
        cycle(1'b0, 1'b0);
        cycle(1'b0, 1'b1);

        // Exhaustive sweep of every 8-sample sequence after a reset.
        for (int s = 0; s < 256; s++) begin
            cycle(1'b0, 1'b0);
            for (int i = 0; i < 8; i++) cycle(1'b1, s[i]);
        end

        // R7 directed: stale history 1, reset, then 0 must not flag, then 1 must.
        after_mid = 1'b1;
        cycle(1'b1, 1'b1);
        cycle(1'b1, 1'b1);
        cycle(1'b0, 1'b1);
        cycle(1'b1, 1'b0);
        cycle(1'b1, 1'b1);
        cycle(1'b0, 1'b0);
        cycle(1'b1, 1'b1);
        cycle(1'b1, 1'b0);

        // Random stream with occasional resets mid-stream (R7).
        for (int k = 0; k < 3000; k++) begin
            cycle(($urandom % 40) != 0, 1'($urandom % 2));
        end

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule